// File: doc/BRIEF.md
# Software Store Command Sequence Detector

This block watches the access events of an asynchronous-style memory after they have been sampled into the system clock domain. Each event carries a 13-bit address, a read/write flag, a chip-enable qualifier and the output-enable level. The block looks for one fixed chain of six reads. When the chain completes, it sends a one-cycle store request to the mode controller and blocks host access until that controller reports that the store is finished.

Access events arrive on a valid-only stream, `acc_valid`, with no back-pressure. A cycle with `acc_valid` high is one access, and the block consumes it in that same cycle. An event that arrives while host access is blocked is consumed and dropped. The store request and the completion input are plain control pins.

Top module: `store_seq_detect`

## Requirements
- R1: After reset, `store_start` and `host_block` are low and no step of the sequence is matched.
- R2: Six read events to 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and 0x0F0F, in that order, make `store_start` high in the cycle after the sixth event is sampled.
- R3: A read to any address other than the next expected one aborts the partial match, and no store is requested for that attempt.
- R4: A write event (`acc_write`=1) resets the match at any step, even when it targets the expected address.
- R5: The level of `acc_oe` has no effect on matching.
- R6: Only cycles with `acc_valid`=1 and `acc_ce`=1 count as accesses. Other cycles leave the match unchanged.
- R7: `host_block` rises together with `store_start` and stays high until `store_done` is sampled high. It falls in the following cycle.
- R8: When an aborting read targets 0x0000, the match restarts with that read counted as step one, so the next expected address is 0x1555.
- R9: Events that arrive while `host_block` is high are ignored. When the store completes, the match is cleared, so any earlier partial match is lost.
- R10: `store_start` is a single-cycle pulse, and no new pulse can occur while `host_block` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access event is present this cycle |
| acc_addr | input | 13 | Access address |
| acc_write | input | 1 | 1 = write event, 0 = read event |
| acc_ce | input | 1 | Chip-enable qualifier of the event |
| acc_oe | input | 1 | Output-enable level (ignored) |
| store_done | input | 1 | Mode controller reports that the store has finished |
| store_start | output | 1 | One-cycle store request |
| host_block | output | 1 | Host access disabled while high |

## Verification
The bench covers several ways the match can be broken or wrongly kept.

- **Stray read mid-chain.** A design that failed to abort would still request a store.
- **Write to the expected address.** A design that only compared addresses would advance on it.
- **Re-read of 0x0000 after a partial chain.** A design without the restart would demand an extra read.
- **Events with chip-enable low.** These sit between steps; a design that counted them would abort.
- **A complete chain sent while blocked, then a tail sent after completion.** These catch a design that keeps the match state across a store, or one that raises a second request during the store.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  localparam int ADDR_W = 13;
  localparam int STEPS  = 6;
  localparam int STEP_W = $clog2(STEPS);
  localparam int SLOTS  = 1 << STEP_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STEP_W-1:0] step_t;

  function automatic addr_t chain_addr(input int idx);
    case (idx)
      0:       chain_addr = 13'h0000;
      1:       chain_addr = 13'h1555;
      2:       chain_addr = 13'h0AAA;
      3:       chain_addr = 13'h1FFF;
      4:       chain_addr = 13'h10F0;
      default: chain_addr = 13'h0F0F;
    endcase
  endfunction
endpackage

// File: rtl/sseq_step_match.sv
module sseq_step_match
  import sseq_pkg::*;
(
  input  addr_t addr,
  input  step_t step,
  output logic  hit_step,
  output logic  hit_first
);
  logic [SLOTS-1:0] eq;

  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    if (i < STEPS) begin : g_real
      assign eq[i] = (addr == chain_addr(i));
    end else begin : g_pad
      assign eq[i] = 1'b0;
    end
  end

  assign hit_step  = eq[step];
  assign hit_first = eq[0];
endmodule

// File: rtl/sseq_tracker.sv
module sseq_tracker
  import sseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  evt,
  input  logic  is_wr,
  input  logic  hit_step,
  input  logic  hit_first,
  input  logic  blocked,
  input  logic  clear,
  output step_t step,
  output logic  final_hit
);
  logic live;
  logic last_step;

  assign live      = evt && !blocked;
  assign last_step = (step == step_t'(STEPS - 1));
  assign final_hit = live && !is_wr && hit_step && last_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0;
    end else if (blocked) begin
      if (clear) step <= '0;
    end else if (live) begin
      if (!is_wr && hit_step)
        step <= last_step ? '0 : step + 1'b1;
      else if (!is_wr && hit_first)
        step <= step_t'(1);
      else
        step <= '0;
    end
  end

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step < step_t'(STEPS)); // R1
  AST_WRITE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (live && is_wr) |=> (step == '0)); // R4
  AST_RESTART_AT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !is_wr && !hit_step && hit_first) |=> (step == step_t'(1))); // R8
  AST_BLOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !clear) |=> $stable(step)); // R9
endmodule

// File: rtl/sseq_store_ctl.sv
module sseq_store_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic final_hit,
  input  logic store_done,
  output logic store_start,
  output logic host_block
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_start <= 1'b0;
      host_block  <= 1'b0;
    end else begin
      store_start <= final_hit && !host_block;
      if (host_block) begin
        if (store_done) host_block <= 1'b0;
      end else if (final_hit) begin
        host_block <= 1'b1;
      end
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |=> !store_start); // R10
  AST_START_WITH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> host_block); // R7
  AST_NO_START_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> !$past(host_block)); // R10
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_block && store_done) |=> !host_block); // R7
endmodule

// File: rtl/store_seq_detect.sv
module store_seq_detect
  import sseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_ce,
  input  logic              acc_oe,
  input  logic              store_done,
  output logic              store_start,
  output logic              host_block
);
  logic  evt;
  logic  hit_step;
  logic  hit_first;
  logic  final_hit;
  step_t step;

  assign evt = acc_valid && acc_ce;

  sseq_step_match u_match (
    .addr      (acc_addr),
    .step      (step),
    .hit_step  (hit_step),
    .hit_first (hit_first)
  );

  sseq_tracker u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .is_wr     (acc_write),
    .hit_step  (hit_step),
    .hit_first (hit_first),
    .blocked   (host_block),
    .clear     (store_done),
    .step      (step),
    .final_hit (final_hit)
  );

  sseq_store_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .final_hit   (final_hit),
    .store_done  (store_done),
    .store_start (store_start),
    .host_block  (host_block)
  );

  AST_OE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !acc_oe && !acc_write && !host_block && hit_step &&
     step == step_t'(STEPS - 1)) |=> store_start); // R5
  AST_NO_CE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !host_block) |=> $stable(step)); // R6
  AST_CHAIN_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !acc_write && !host_block && acc_addr == chain_addr(STEPS - 1) &&
     step == step_t'(STEPS - 1)) |=> store_start); // R2
endmodule

// File: tb/sim_store_seq_detect.sv
module sim_store_seq_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [12:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_ce = 1'b0;
  logic        acc_oe = 1'b0;
  logic        store_done = 1'b0;
  logic        store_start;
  logic        host_block;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  string cur_req = "R1";

  int seq[$] = '{'h0000, 'h1555, 'h0AAA, 'h1FFF, 'h10F0, 'h0F0F};
  int m_k = 0;
  bit m_start = 0;
  bit m_block = 0;

  always #2 clk = ~clk;

  store_seq_detect u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_ce(acc_ce), .acc_oe(acc_oe),
    .store_done(store_done), .store_start(store_start), .host_block(host_block)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_k <= 0; m_start <= 0; m_block <= 0;
    end else begin
      m_start <= 0;
      if (m_block) begin
        if (store_done) begin m_block <= 0; m_k <= 0; end
      end else if (acc_valid && acc_ce) begin
        if (!acc_write && int'(acc_addr) == seq[m_k]) begin
          if (m_k == seq.size() - 1) begin
            m_start <= 1; m_block <= 1; m_k <= 0;
          end else m_k <= m_k + 1;
        end else if (!acc_write && acc_addr == 13'h0000) m_k <= 1;
        else m_k <= 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (store_start) starts++;
    check(cur_req, store_start, m_start, "store_start vs model");
    check(cur_req, host_block, m_block, "host_block vs model");
  end

  task automatic ev(input int a, input bit wr, input bit ce, input bit oe);
    @(negedge clk);
    acc_valid = 1; acc_addr = 13'(a); acc_write = wr; acc_ce = ce; acc_oe = oe;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_ce = 0;
  endtask

  task automatic chain(input int from, input bit oe);
    for (int i = from; i < 6; i++) ev(seq[i], 0, 1, oe);
  endtask

  task automatic finish_store();
    repeat (3) @(negedge clk);
    store_done = 1;
    @(negedge clk);
    store_done = 0;
    @(negedge clk);
  endtask

  task automatic expect_starts(input string req, input int n);
    @(negedge clk); @(negedge clk);
    check(req, starts, n, "store request count");
    starts = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", store_start, 0, "start in reset");
    check("R1", host_block, 0, "block in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", host_block, 0, "block after reset");

    cur_req = "R2"; chain(0, 1);
    check("R7", host_block, 1, "block after chain");
    expect_starts("R2", 1);
    cur_req = "R7"; finish_store();
    check("R7", host_block, 0, "block released");

    cur_req = "R5"; chain(0, 0); expect_starts("R5", 1); finish_store();

    cur_req = "R3";
    chain(0, 1); // overwritten below: run partial then stray
    finish_store(); starts = 0;
    for (int i = 0; i < 3; i++) ev(seq[i], 0, 1, 1);
    ev('h1234, 0, 1, 1);
    for (int i = 3; i < 6; i++) ev(seq[i], 0, 1, 1);
    expect_starts("R3", 0);

    cur_req = "R4";
    for (int i = 0; i < 3; i++) ev(seq[i], 0, 1, 1);
    ev(seq[3], 1, 1, 1);
    for (int i = 3; i < 6; i++) ev(seq[i], 0, 1, 1);
    expect_starts("R4", 0);

    cur_req = "R6";
    for (int i = 0; i < 6; i++) begin
      ev(seq[i], 0, 1, 1);
      ev('h0777, 0, 0, 1);
      ev('h0333, 1, 0, 0);
    end
    expect_starts("R6", 1); finish_store();

    cur_req = "R8";
    for (int i = 0; i < 4; i++) ev(seq[i], 0, 1, 1);
    ev('h0000, 0, 1, 1);
    chain(1, 1);
    expect_starts("R8", 1); finish_store();

    cur_req = "R9";
    chain(0, 1);
    chain(0, 1);
    expect_starts("R9", 1);
    check("R9", host_block, 1, "still blocked");
    for (int i = 0; i < 3; i++) ev(seq[i], 0, 1, 1);
    finish_store();
    chain(3, 1);
    expect_starts("R9", 0);
    chain(0, 1);
    expect_starts("R10", 1); finish_store();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule